// File: doc/BRIEF.md
# Burst Received-Power Capture Controller

This block measures received optical power during a burst slot. A host acquisition strobe frames the measurement. The rising edge of the strobe opens a sampling window. While the window is open, the block asks an ADC for 12-bit power readings over a request/valid handshake and accumulates them. The falling edge closes the window and loads the averaged reading into a 16-bit result register, which the management interface reads.

A valid flag marks the result as ready. The host must wait for that flag before it strobes again. A strobe that comes too early is dropped, and a sticky overrun bit records it. If the window closes before the full averaging depth is reached, the block averages the samples it has. If the window closes with no samples at all, it reports zero and sets an underflow bit.

Top module: `burst_rssi_capture`

## Requirements
- R1: After reset, adc_req, rssi_valid, overrun and underflow are 0 and rssi_result is 0.
- R2: The strobe passes through a two-stage synchroniser. After a strobe rising edge set up before clock edge E0, adc_req is still 0 after E1 and is 1 after E2. Pulses shorter than two cycles may be missed.
- R3: adc_req stays high for the whole open window, so a sample is taken on every clock edge where adc_valid is high. adc_req drops when the window closes and is never high while rssi_valid is high.
- R4: When 8 or more samples arrive in a window, the result is the sum of the first 8 shifted right by 3. Later samples in that window are ignored. The result is zero-extended, so bits 15:12 are 0.
- R5: When 1 to 7 samples arrive, the result is the integer part of their sum divided by their count.
- R6: When no sample arrives, the result is 0 and underflow is 1. Underflow clears on the next accepted rising edge.
- R7: A strobe falling edge set up before E0 loads rssi_result at E2. rssi_valid rises at E3, one cycle after the load.
- R8: rssi_valid clears on the next accepted rising edge, on the same edge that adc_req rises.
- R9: A rising edge seen while a capture is pending, before rssi_valid has risen, is ignored and sets overrun. No window opens, and rssi_result and rssi_valid are not disturbed. Overrun stays set until reset.
- R10: A falling edge while no window is open has no effect on rssi_result, rssi_valid or adc_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_strobe | input | 1 | Host acquisition strobe, asynchronous |
| adc_req | output | 1 | Sample request to the ADC |
| adc_valid | input | 1 | ADC sample valid |
| adc_data | input | 12 | ADC power sample |
| rssi_result | output | 16 | Averaged power reading |
| rssi_valid | output | 1 | Result ready |
| overrun | output | 1 | Sticky: early strobe was dropped |
| underflow | output | 1 | Last window held no sample |

## Verification
A wrong sample count or sum shows up only as a wrong rssi_result. It appears two edges after the synchronised falling edge. Test windows of 0, 1, 3, 7, 8 and 10 samples each give a distinct expected value, so every averaging branch is exposed. A wrong control state shows up within one to three cycles as adc_req, rssi_valid or overrun at the wrong time. An early re-strobe must leave adc_req low and rssi_valid high.

// File: rtl/rssi_pkg.sv
package rssi_pkg;
   typedef enum logic [1:0] {
      CAP_IDLE   = 2'd0,
      CAP_OPEN   = 2'd1,
      CAP_COMMIT = 2'd2
   } cap_state_t;
endpackage

// File: rtl/rssi_strobe_sync.sv
module rssi_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   // chain[STAGES-1] is the synchronised level, chain[STAGES] its history
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign rise =  chain[STAGES-1] & ~chain[STAGES];
   assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/rssi_accum.sv
module rssi_accum #(
   parameter int SAMPLE_W      = 12,
   parameter int AVG_LOG2      = 3,
   parameter bit EXACT_PARTIAL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    take,
   input  logic [SAMPLE_W-1:0]     sample,
   output logic [AVG_LOG2:0]       count,
   output logic [SAMPLE_W-1:0]     avg
);
   localparam int SUM_W = SAMPLE_W + AVG_LOG2;
   localparam int CNT_W = AVG_LOG2 + 1;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(1 << AVG_LOG2);

   logic [SUM_W-1:0] sum;
   logic [SAMPLE_W-1:0] partial;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum   <= '0;
         count <= '0;
      end else if (clear) begin
         sum   <= '0;
         count <= '0;
      end else if (take && count < FULL) begin
         sum   <= sum + SUM_W'(sample);
         count <= count + 1'b1;
      end
   end

   generate
      if (EXACT_PARTIAL) begin : g_divide
         assign partial = SAMPLE_W'(sum / SUM_W'(count));
      end else begin : g_shift
         assign partial = SAMPLE_W'(sum >> AVG_LOG2);
      end
   endgenerate

   always_comb begin
      if (count == '0)        avg = '0;
      else if (count == FULL) avg = SAMPLE_W'(sum >> AVG_LOG2);
      else                    avg = partial;
   end
endmodule

// File: rtl/burst_rssi_capture.sv
module burst_rssi_capture #(
   parameter int SAMPLE_W      = 12,
   parameter int RESULT_W      = 16,
   parameter int AVG_LOG2      = 3,
   parameter int SYNC_STAGES   = 2,
   parameter bit EXACT_PARTIAL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acq_strobe,
   output logic                adc_req,
   input  logic                adc_valid,
   input  logic [SAMPLE_W-1:0] adc_data,
   output logic [RESULT_W-1:0] rssi_result,
   output logic                rssi_valid,
   output logic                overrun,
   output logic                underflow
);
   import rssi_pkg::*;

   generate
      if (RESULT_W < SAMPLE_W) begin : g_bad_width
         $error("RESULT_W must be at least SAMPLE_W");
      end
      if (AVG_LOG2 < 1) begin : g_bad_depth
         $error("AVG_LOG2 must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   cap_state_t state;
   logic rise, fall, take, clear;
   logic [AVG_LOG2:0] count;
   logic [SAMPLE_W-1:0] avg;

   rssi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(acq_strobe), .rise(rise), .fall(fall)
   );

   assign clear = (state == CAP_IDLE) && rise;
   assign take  = (state == CAP_OPEN) && adc_req && adc_valid && !fall;

   rssi_accum #(
      .SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2), .EXACT_PARTIAL(EXACT_PARTIAL)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(clear), .take(take),
      .sample(adc_data), .count(count), .avg(avg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= CAP_IDLE;
         adc_req     <= 1'b0;
         rssi_result <= '0;
         rssi_valid  <= 1'b0;
         overrun     <= 1'b0;
         underflow   <= 1'b0;
      end else begin
         case (state)
            CAP_IDLE: begin
               if (rise) begin
                  state      <= CAP_OPEN;
                  adc_req    <= 1'b1;
                  rssi_valid <= 1'b0;
                  underflow  <= 1'b0;
               end
            end
            CAP_OPEN: begin
               if (fall) begin
                  state       <= CAP_COMMIT;
                  adc_req     <= 1'b0;
                  rssi_result <= RESULT_W'(avg);
                  underflow   <= (count == '0);
               end else if (rise) begin
                  overrun <= 1'b1;
               end
            end
            CAP_COMMIT: begin
               state      <= CAP_IDLE;
               rssi_valid <= 1'b1;
               if (rise) overrun <= 1'b1;
            end
            default: state <= CAP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rssi_capture_chk.sv
module rssi_capture_chk #(
   parameter int RESULT_W = 16,
   parameter int SAMPLE_W = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                adc_req,
   input logic [RESULT_W-1:0] rssi_result,
   input logic                rssi_valid,
   input logic                overrun,
   input logic                underflow
);
   a_r3_req_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req |-> !rssi_valid);

   a_r4_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rssi_result[RESULT_W-1:SAMPLE_W] == '0);

   a_r6_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> rssi_result == '0);

   a_r7_valid_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rssi_valid) |-> !adc_req);

   a_r8_valid_clears_on_open: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rssi_valid) |-> adc_req);

   a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rssi_valid && $past(rssi_valid)) |-> $stable(rssi_result));
endmodule

bind burst_rssi_capture rssi_capture_chk #(.RESULT_W(RESULT_W), .SAMPLE_W(SAMPLE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .adc_req(adc_req), .rssi_result(rssi_result),
   .rssi_valid(rssi_valid), .overrun(overrun), .underflow(underflow)
);

// File: tb/sim_burst_rssi_capture.sv
module sim_burst_rssi_capture;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 5;
   localparam int VN [NV] = '{8, 10, 3, 1, 7};
   localparam logic [11:0] VS [NV][10] = '{
      '{12'd100, 12'd200, 12'd300, 12'd400, 12'd500, 12'd600, 12'd700, 12'd801, 12'd0, 12'd0},
      '{12'd16, 12'd16, 12'd16, 12'd16, 12'd16, 12'd16, 12'd16, 12'd16, 12'hFFF, 12'hFFF},
      '{12'd10, 12'd20, 12'd31, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0},
      '{12'd2749, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0},
      '{12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 12'd0, 12'd0, 12'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0, acq_strobe = 1'b0, adc_valid = 1'b0;
   logic [11:0] adc_data = '0;
   logic adc_req, rssi_valid, overrun, underflow;
   logic [15:0] rssi_result;
   int n_run = 0, n_fail = 0;
   logic [11:0] cur [10];

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_rssi_capture u0 (
      .clk(clk), .rst_n(rst_n), .acq_strobe(acq_strobe), .adc_req(adc_req),
      .adc_valid(adc_valid), .adc_data(adc_data), .rssi_result(rssi_result),
      .rssi_valid(rssi_valid), .overrun(overrun), .underflow(underflow)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] expect_avg(input int n);
      int s = 0;
      int k = (n > 8) ? 8 : n;
      for (int i = 0; i < k; i++) s += int'(cur[i]);
      if (k == 0) return 16'd0;
      return 16'(s / k);
   endfunction

   // opens a window, feeds n samples from cur, closes it, checks the commit
   task automatic capture(input int n, input bit chk_uf_clear);
      logic [15:0] exp = expect_avg(n);
      @(negedge clk); acq_strobe = 1'b1;
      @(negedge clk);
      @(negedge clk); check("R2 req before sync", 32'(adc_req), 0);
      @(negedge clk); check("R2 req after sync", 32'(adc_req), 1);
      check("R8 valid cleared on open", 32'(rssi_valid), 0);
      if (chk_uf_clear) check("R6 underflow cleared", 32'(underflow), 0);
      for (int i = 0; i < n; i++) begin
         adc_valid = 1'b1; adc_data = cur[i];
         @(negedge clk);
      end
      adc_valid = 1'b0;
      check("R3 req held in window", 32'(adc_req), 1);
      acq_strobe = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check((n >= 8) ? "R4 full average" : (n == 0 ? "R6 empty result" : "R5 partial average"),
            32'(rssi_result), 32'(exp));
      check("R7 valid one cycle after load", 32'(rssi_valid), 0);
      check("R3 req dropped at close", 32'(adc_req), 0);
      @(negedge clk);
      check("R7 valid raised", 32'(rssi_valid), 1);
      check("R6 underflow flag", 32'(underflow), (n == 0) ? 1 : 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 req", 32'(adc_req), 0);
      check("R1 valid", 32'(rssi_valid), 0);
      check("R1 result", 32'(rssi_result), 0);
      check("R1 overrun", 32'(overrun), 0);
      check("R1 underflow", 32'(underflow), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         for (int i = 0; i < 10; i++) cur[i] = VS[v][i];
         capture(VN[v], 1'b0);
      end

      // R6: empty window, then the next accepted rise clears underflow
      capture(0, 1'b0);
      cur[0] = 12'd40; cur[1] = 12'd41;
      capture(2, 1'b1);

      // R9: strobe low for one cycle, rising again while the commit is pending
      @(negedge clk); acq_strobe = 1'b1;
      repeat (3) @(negedge clk);
      cur[0] = 12'd500; cur[1] = 12'd703;
      for (int i = 0; i < 2; i++) begin
         adc_valid = 1'b1; adc_data = cur[i];
         @(negedge clk);
      end
      adc_valid = 1'b0;
      acq_strobe = 1'b0;
      @(negedge clk); acq_strobe = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 overrun set", 32'(overrun), 1);
      check("R9 valid kept", 32'(rssi_valid), 1);
      check("R9 result kept", 32'(rssi_result), 32'd601);
      repeat (3) @(negedge clk);
      check("R9 no window opened", 32'(adc_req), 0);

      // R10: falling edge with no window open
      acq_strobe = 1'b0;
      repeat (5) @(negedge clk);
      check("R10 valid unchanged", 32'(rssi_valid), 1);
      check("R10 result unchanged", 32'(rssi_result), 32'd601);
      check("R10 req unchanged", 32'(adc_req), 0);

      cur[0] = 12'd9;
      capture(1, 1'b0);
      check("R9 overrun sticky", 32'(overrun), 1);

      // R1: reset in service clears everything
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 overrun cleared", 32'(overrun), 0);
      check("R1 result cleared", 32'(rssi_result), 0);
      check("R1 valid cleared", 32'(rssi_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule